// File: doc/BRIEF.md
# Ethernet PHY LED Controller

This block turns the link and activity status of an Ethernet PHY into four LED drive signals. Each LED has two 8-bit configuration words. The first word holds a constant-on selector and a fast-blink selector. The second word holds a slow-blink selector and three pulse enables. Two square-wave timebases, one slow and one fast, are shared by every LED. Their rates come from a common blink-control word, with a choice of 2, 4, 8 or 16 Hz. Activity strobes for transmit, receive and collision are stretched so that they stay visible. When a stretched strobe is enabled for an LED, it briefly flips that LED away from its base state.

A mode register selects, for each LED, either hardware-driven behaviour or a software direct-drive bit. The same register holds a per-LED output inversion, which is applied last. Software reaches all of this through a flat register port. Writes are synchronous and reads are combinational.

Register addresses: the configuration words for LED i sit at 2i (condition word) and 2i+1 (slow/pulse word). The blink-control word is at 2·NUM_LEDS and the mode register is at 2·NUM_LEDS+1.

Top module: `phyled_top`

## Requirements
- R1: After reset, every configuration word and the blink-control word read as 0 and the mode register reads 0x0F00 (all hardware enables set). With all configuration zero, every LED output is 0.
- R2: Configuration words read back their 8 written bits, with bits [15:8] reading 0. The blink-control word keeps only bits [7:4]. The mode register keeps bits [15:12] (invert), [11:8] (hardware enable) and [3:0] (direct value); its bits [7:4] always read 0.
- R3: A condition code is evaluated as follows. Codes 1..7 are a speed mask, with bit0 = 10 Mb/s, bit1 = 100 Mb/s and bit2 = 1000 Mb/s. Such a code matches only while link is up and the speed input (0 = 10, 1 = 100, 2 = 1000, 3 = none) hits a set bit. Code 8 matches power-down, code 9 matches EEE active and code 10 matches autonegotiation. Codes 0 and 11..15 never match. The constant-on selector is bits [7:4] of the condition word.
- R4: When the fast-blink selector (condition word bits [3:0]) matches, the LED follows the fast square wave. Its rate is chosen by blink-control bits [7:6]: 0, 1, 2 and 3 select 2, 4, 8 and 16 Hz. Rate code r toggles every TICK_CYCLES·2^(3−r) clocks, counted from reset release.
- R5: When the slow-blink selector (slow/pulse word bits [7:4]) matches, the LED follows the slow square wave, whose rate is chosen by blink-control bits [5:4] with the same coding as R4.
- R6: Priority among the base conditions is fast blink, then slow blink, then constant-on; the LED is 0 when none matches.
- R7: Slow/pulse word bit0 enables transmit pulses, bit1 receive pulses and bit2 collision pulses. While an enabled stretched strobe is active, the LED shows the inverse of its base state. A strobe whose enable is clear has no effect.
- R8: A one-cycle strobe makes its stretched activity active for exactly STRETCH_CYCLES cycles, starting at the next clock edge. A strobe that arrives during the window restarts the window.
- R9: With its hardware enable clear, an LED shows its direct value from the mode register, whatever its configuration.
- R10: The inversion bit is applied after the choice between hardware and direct drive.
- R11: LEDs that blink at the same rate are in phase, even when one uses the fast selector and the other uses the slow selector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address for both reads and writes |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| link_up | input | 1 | Link established |
| link_speed | input | 2 | 0 = 10, 1 = 100, 2 = 1000 Mb/s, 3 = none |
| pdown | input | 1 | PHY in power-down |
| eee_active | input | 1 | Energy-efficient mode active |
| aneg_busy | input | 1 | Autonegotiation in progress |
| tx_strobe | input | 1 | Transmit activity strobe |
| rx_strobe | input | 1 | Receive activity strobe |
| col_strobe | input | 1 | Collision strobe |
| led_o | output | NUM_LEDS | LED drive outputs |

## Verification
The hardest case to reach from the ports is timing a blink waveform against an absolute phase. The phase comes from a free-running divider that software cannot read or reset. The bench therefore counts clock edges from reset release itself and predicts every sample of each wave arithmetically. It runs with a short tick so that all four rates cycle through completely within a few dozen clocks. Pulse stretch length and retrigger extension are measured by counting the cycles in which the LED differs from its base state.

// File: rtl/phyled_pkg.sv
package phyled_pkg;

  typedef struct packed {
    logic       link_up;
    logic [1:0] speed;   // 0:10 1:100 2:1000 3:none
    logic       pdown;
    logic       eee;
    logic       aneg;
  } phy_status_t;

  // Does a 4-bit condition code match the present PHY status?
  function automatic logic cond_hit(input logic [3:0] code, input phy_status_t st);
    logic r;
    r = 1'b0;
    if (code >= 4'd1 && code <= 4'd7)
      r = st.link_up && (st.speed != 2'd3) && code[st.speed];
    else if (code == 4'd8)  r = st.pdown;
    else if (code == 4'd9)  r = st.eee;
    else if (code == 4'd10) r = st.aneg;
    return r;
  endfunction

  // Rate code 0..3 picks 2/4/8/16 Hz out of the shared phase counter.
  function automatic logic rate_wave(input logic [1:0] rate, input logic [3:0] phase);
    return phase[2'd3 - rate];
  endfunction

endpackage

// File: rtl/phyled_timebase.sv
module phyled_timebase #(
  parameter int TICK_CYCLES = 3125000
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic [3:0] phase
);
  localparam int CW = $clog2(TICK_CYCLES + 1);

  logic [CW-1:0] div_q;
  logic          tick;

  assign tick = (div_q == CW'(TICK_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      phase <= '0;
    end else if (tick) begin
      div_q <= '0;
      phase <= phase + 4'd1;
    end else begin
      div_q <= div_q + CW'(1);
    end
  end

  assert_phase_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> phase == $past(phase) + 4'd1);
  assert_phase_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(phase));
endmodule

// File: rtl/phyled_stretch.sv
module phyled_stretch #(
  parameter int STRETCH_CYCLES = 3000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic active
);
  localparam int SW = $clog2(STRETCH_CYCLES + 1);

  logic [SW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              left_q <= '0;
    else if (strobe)         left_q <= SW'(STRETCH_CYCLES);
    else if (left_q != '0)   left_q <= left_q - SW'(1);
  end

  assign active = (left_q != '0);

  assert_stretch_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> active && left_q == SW'(STRETCH_CYCLES));
  assert_stretch_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    left_q <= SW'(STRETCH_CYCLES));
endmodule

// File: rtl/phyled_channel.sv
module phyled_channel
  import phyled_pkg::*;
(
  input  logic        [7:0] cond_word,
  input  logic        [7:0] slow_word,
  input  logic        [1:0] fast_rate,
  input  logic        [1:0] slow_rate,
  input  logic        [3:0] phase,
  input  phy_status_t       st,
  input  logic        [2:0] act,
  input  logic              hw_en,
  input  logic              direct,
  input  logic              invert,
  output logic              led
);
  logic on_hit, fast_hit, slow_hit, pulse_hit, base, hw_val, chosen;

  always_comb begin
    on_hit    = cond_hit(cond_word[7:4], st);
    fast_hit  = cond_hit(cond_word[3:0], st);
    slow_hit  = cond_hit(slow_word[7:4], st);
    pulse_hit = |(slow_word[3:0] & {1'b0, act});
    if (fast_hit)      base = rate_wave(fast_rate, phase);
    else if (slow_hit) base = rate_wave(slow_rate, phase);
    else               base = on_hit;
    hw_val = base ^ pulse_hit;
    chosen = hw_en ? hw_val : direct;
    led    = chosen ^ invert;
  end
endmodule

// File: rtl/phyled_top.sv
module phyled_top
  import phyled_pkg::*;
#(
  parameter int NUM_LEDS       = 4,
  parameter int ADDR_W         = 4,
  parameter int CLK_HZ         = 100000000,
  parameter int TICK_CYCLES    = CLK_HZ / 32,
  parameter int STRETCH_CYCLES = (CLK_HZ / 1000) * 30
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [15:0]         wdata,
  output logic [15:0]         rdata,
  input  logic                link_up,
  input  logic [1:0]          link_speed,
  input  logic                pdown,
  input  logic                eee_active,
  input  logic                aneg_busy,
  input  logic                tx_strobe,
  input  logic                rx_strobe,
  input  logic                col_strobe,
  output logic [NUM_LEDS-1:0] led_o
);
  localparam int NCFG  = 2 * NUM_LEDS;
  localparam int IDX_W = $clog2(NCFG);
  localparam logic [ADDR_W-1:0] BLINK_ADDR = ADDR_W'(NCFG);
  localparam logic [ADDR_W-1:0] MODE_ADDR  = ADDR_W'(NCFG + 1);
  localparam logic [15:0] LED_M     = 16'((1 << NUM_LEDS) - 1);
  localparam logic [15:0] MODE_MASK = (LED_M << 12) | (LED_M << 8) | LED_M;
  localparam logic [15:0] MODE_RST  = LED_M << 8;

  logic [7:0]  cfg_q [NCFG];
  logic [3:0]  blink_q;   // [3:2] fast rate, [1:0] slow rate
  logic [15:0] mode_q;
  logic [3:0]  phase;
  logic [2:0]  act;
  phy_status_t st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NCFG; k++) cfg_q[k] <= '0;
      blink_q <= '0;
      mode_q  <= MODE_RST;
    end else if (wr_en) begin
      if (addr < ADDR_W'(NCFG))  cfg_q[addr[IDX_W-1:0]] <= wdata[7:0];
      else if (addr == BLINK_ADDR) blink_q <= wdata[7:4];
      else if (addr == MODE_ADDR)  mode_q  <= wdata & MODE_MASK;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr < ADDR_W'(NCFG))    rdata = {8'h00, cfg_q[addr[IDX_W-1:0]]};
    else if (addr == BLINK_ADDR) rdata = {8'h00, blink_q, 4'h0};
    else if (addr == MODE_ADDR)  rdata = mode_q;
  end

  assign st = '{link_up: link_up, speed: link_speed, pdown: pdown,
                eee: eee_active, aneg: aneg_busy};

  phyled_timebase #(.TICK_CYCLES(TICK_CYCLES)) u_tb (
    .clk(clk), .rst_n(rst_n), .phase(phase));

  logic [2:0] strobes;
  assign strobes = {col_strobe, rx_strobe, tx_strobe};

  for (genvar s = 0; s < 3; s++) begin : g_str
    phyled_stretch #(.STRETCH_CYCLES(STRETCH_CYCLES)) u_str (
      .clk(clk), .rst_n(rst_n), .strobe(strobes[s]), .active(act[s]));
  end

  for (genvar i = 0; i < NUM_LEDS; i++) begin : g_led
    phyled_channel u_ch (
      .cond_word(cfg_q[2*i]),
      .slow_word(cfg_q[2*i+1]),
      .fast_rate(blink_q[3:2]),
      .slow_rate(blink_q[1:0]),
      .phase(phase),
      .st(st),
      .act(act),
      .hw_en(mode_q[8+i]),
      .direct(mode_q[i]),
      .invert(mode_q[12+i]),
      .led(led_o[i]));

    assert_direct_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_q[8+i] |-> led_o[i] == (mode_q[i] ^ mode_q[12+i]));
  end

  assert_mode_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == MODE_ADDR) |=> mode_q == ($past(wdata) & MODE_MASK));
  assert_mode_reserved_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[7:4] == 4'h0);
endmodule

// File: tb/tb_phyled_top.sv
module tb_phyled_top;
  localparam int N = 4;
  localparam int TICK = 2;
  localparam int STR = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic link_up = 1'b0;
  logic [1:0] link_speed = 2'd0;
  logic pdown = 1'b0, eee_active = 1'b0, aneg_busy = 1'b0;
  logic tx_strobe = 1'b0, rx_strobe = 1'b0, col_strobe = 1'b0;
  logic [N-1:0] led_o;

  int checks = 0;
  int errors = 0;
  int edges = 0;
  bit done = 0;

  always #5 clk = ~clk;
  always @(posedge clk) if (rst_n) edges++;

  phyled_top #(.NUM_LEDS(N), .ADDR_W(4), .CLK_HZ(1000),
               .TICK_CYCLES(TICK), .STRETCH_CYCLES(STR)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .link_up(link_up), .link_speed(link_speed), .pdown(pdown),
    .eee_active(eee_active), .aneg_busy(aneg_busy), .tx_strobe(tx_strobe),
    .rx_strobe(rx_strobe), .col_strobe(col_strobe), .led_o(led_o));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; addr = 4'(a); wdata = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_check(input string req, input int a, input int exp);
    addr = 4'(a);
    #1;
    check(req, rdata, 16'(exp));
  endtask

  function automatic logic exp_cond(input int code, input logic lk, input int spd,
                                    input logic pd, input logic ee, input logic an);
    case (code)
      1, 2, 3, 4, 5, 6, 7: return lk && spd < 3 && ((code / (1 << spd)) % 2 == 1);
      8:  return pd;
      9:  return ee;
      10: return an;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic exp_wave(input int rate);
    return ((edges / TICK) / (1 << (3 - rate))) % 2 == 1;
  endfunction

  // count samples where led bit b differs from 'base' over a window
  task automatic pulse_count(input int b, input logic base, input int len, output int cnt);
    cnt = 0;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      tx_strobe = 1'b0; rx_strobe = 1'b0; col_strobe = 1'b0;
      #1;
      if (led_o[b] != base) cnt++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 2 * N; a++) rd_check("R1 cfg reset", a, 0);
    rd_check("R1 blink reset", 2 * N, 0);
    rd_check("R1 mode reset", 2 * N + 1, 16'h0F00);
    check("R1 leds off", 16'(led_o), 16'h0);

    // R2 readback and masking
    wr(3, 16'hFFA5);
    rd_check("R2 cfg readback", 3, 16'h00A5);
    wr(2 * N, 16'hFFFF);
    rd_check("R2 blink mask", 2 * N, 16'h00F0);
    wr(2 * N + 1, 16'hFFFF);
    rd_check("R2 mode mask", 2 * N + 1, 16'hFF0F);
    wr(2 * N + 1, 16'h0F00);
    wr(2 * N, 0);
    for (int a = 0; a < 2 * N; a++) wr(a, 0);

    // R3 condition sweep on constant-on selector
    for (int code = 0; code < 16; code++) begin
      wr(2 * (code % N), code << 4);
      for (int spd = 0; spd < 4; spd++)
        for (int lk = 0; lk < 2; lk++)
          for (int o = 0; o < 8; o++) begin
            @(negedge clk);
            link_speed = 2'(spd); link_up = lk[0];
            pdown = o[0]; eee_active = o[1]; aneg_busy = o[2];
            #1;
            check("R3 condition code", 16'(led_o[code % N]),
                  16'(exp_cond(code, lk[0], spd, o[0], o[1], o[2])));
          end
      wr(2 * (code % N), 0);
    end
    @(negedge clk);
    pdown = 0; eee_active = 0; aneg_busy = 0; link_up = 1; link_speed = 2'd1;

    // R4 R5 R11 blink rates, shared phase
    wr(0, 16'h0007);          // LED0 fast, any link
    wr(3, 16'h0070);          // LED1 slow, any link
    for (int r = 0; r < 4; r++) begin
      wr(2 * N, (r << 6) | (r << 4));
      for (int k = 0; k < 40; k++) begin
        @(negedge clk); #1;
        check("R4 fast wave", 16'(led_o[0]), 16'(exp_wave(r)));
        check("R5 slow wave", 16'(led_o[1]), 16'(exp_wave(r)));
        check("R11 in phase", 16'(led_o[0]), 16'(led_o[1]));
      end
    end

    // R6 priority: fast=16Hz, slow=2Hz
    wr(2 * N, (3 << 6) | (0 << 4));
    wr(4, 16'h0077); wr(5, 16'h0070);   // LED2 fast+slow+on
    wr(6, 16'h0070); wr(7, 16'h0070);   // LED3 slow+on
    for (int k = 0; k < 40; k++) begin
      @(negedge clk); #1;
      check("R6 fast over slow", 16'(led_o[2]), 16'(exp_wave(3)));
      check("R6 slow over on", 16'(led_o[3]), 16'(exp_wave(0)));
    end
    for (int a = 0; a < 2 * N; a++) wr(a, 0);

    // R7 R8 pulse mapping and stretch length
    for (int b = 0; b < 3; b++)
      for (int s = 0; s < 3; s++) begin
        wr(1, 1 << b);
        repeat (STR + 2) @(negedge clk);
        tx_strobe = (s == 0); rx_strobe = (s == 1); col_strobe = (s == 2);
        pulse_count(0, 1'b0, STR + 4, cnt);
        check("R7 R8 pulse select/length", 16'(cnt), 16'((b == s) ? STR : 0));
      end
    // R8 retrigger extends window
    wr(1, 1);
    repeat (STR + 2) @(negedge clk);
    tx_strobe = 1'b1;
    pulse_count(0, 1'b0, 2, cnt);
    tx_strobe = 1'b1;
    begin
      int c2;
      pulse_count(0, 1'b0, STR + 4, c2);
      check("R8 retrigger", 16'(cnt + c2), 16'(2 + STR));
    end
    // R7 pulse on a lit LED turns it off
    wr(0, 16'h0070);
    repeat (STR + 2) @(negedge clk);
    rx_strobe = 1'b1;
    wr(1, 16'h0002);
    repeat (STR + 2) @(negedge clk);
    rx_strobe = 1'b1;
    pulse_count(0, 1'b1, STR + 4, cnt);
    check("R7 inverted from on", 16'(cnt), 16'(STR));

    // R9 R10 direct drive and inversion sweep (all hw values = 1)
    for (int a = 0; a < N; a++) begin wr(2 * a, 16'h0070); wr(2 * a + 1, 0); end
    for (int m = 0; m < 4096; m++) begin
      int exp;
      wr(2 * N + 1, ((m >> 8) << 12) | (((m >> 4) & 15) << 8) | (m & 15));
      #1;
      exp = 0;
      for (int i = 0; i < N; i++) begin
        int v;
        v = ((m >> (4 + i)) & 1) ? 1 : ((m >> i) & 1);
        v = v ^ ((m >> (8 + i)) & 1);
        exp = exp | (v << i);
      end
      check("R9 R10 drive select/invert", 16'(led_o), 16'(exp));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule